// File: doc/BRIEF.md
# PWM Clock Prescaler Selector

This block takes a requested PWM frequency and works out which clock divider to apply to a fixed 24 MHz reference. It also works out the period count a 16-bit PWM counter then needs. It tries the smallest dividers first and stops at the first one whose period fits in 16 bits. The result is the finest duty-cycle resolution the counter can give for that frequency.

A request is a single-cycle start strobe with the frequency on `freq_i`. The block latches the frequency and steps through candidate dividers. For each candidate it uses one shared shift-subtract divider: the reference is divided by the candidate, and the result is checked against the 16-bit range. When a candidate fits, a second division by the frequency gives the period. The results appear together with a one-cycle completion pulse and stay unchanged until the next completion.

A zero frequency is answered at once. A frequency too low for any divider within the search range is reported as an error.

Top module: `pwm_prescale_sel`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `err_o` and `zero_o` are 0, and `div_o` and `period_o` are 0.
- R2: A start with `freq_i` equal to 0 completes on the accepting clock edge. `done_o` is high right after that edge, with `zero_o`=1, `err_o`=0, `div_o`=0 and `period_o`=0.
- R3: For a nonzero frequency f, `div_o` is the smallest d in 1..366 for which floor(floor(24000000/d)/f) is below 65536.
- R4: `period_o` equals floor(floor(24000000/d)/f) for the selected d. For f=367 this gives d=1 and period 65395. For f=366 it gives d=2 and period 32786.
- R5: If no d in 1..366 fits (f=1), the block reports `err_o`=1, `zero_o`=0, `div_o`=366 and `period_o`=0.
- R6: `done_o` is high for exactly one cycle per completed request. All four result outputs change only on the edge that raises `done_o` and hold their values otherwise.
- R7: A start that arrives while a search is running is ignored, and so is the frequency presented with it. Only one completion follows, and it carries the result for the frequency latched when the search began.
- R8: Frequencies at or above 24000000/65536 Hz need no prescaling: the block selects d=1. A frequency above 24 MHz gives period 0.
- R9: For a nonzero frequency that selects divider d without error, `done_o` rises 26*(d+1) clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| freq_i | input | 25 | Requested PWM frequency in Hz |
| div_o | output | 9 | Selected reference divider |
| period_o | output | 16 | Period count for the PWM counter |
| done_o | output | 1 | One-cycle result-valid pulse |
| zero_o | output | 1 | Last request asked for 0 Hz |
| err_o | output | 1 | Last request found no fitting divider |

## Verification
A candidate counter that is off by one, or that skips a value, shows up at the next completion as a `div_o` one step away from the smallest fitting divider. A wrong remainder or shift in the divider shows up as a wrong `period_o` in that same completion pulse. A stray or missing controller state shifts the completion by whole division slots, so the exact latency check reports it on the first request. A frequency latch that gets overwritten mid-search returns a result for the wrong frequency as soon as that search ends.

// File: rtl/psel_pkg.sv
package psel_pkg;

    // Fixed reference clock and counter geometry
    localparam int unsigned REF_HZ    = 24_000_000;
    localparam int          PER_W     = 16;
    localparam int          FREQ_W    = 25;
    localparam int          REF_W     = $clog2(REF_HZ + 1);
    localparam int          DIVN_W    = (REF_W > FREQ_W) ? REF_W : FREQ_W;

    // Search range: 1 .. DIV_MAX
    localparam int unsigned DIV_LIMIT = REF_HZ / (2 ** PER_W) + 1;
    localparam int unsigned DIV_MAX   = DIV_LIMIT - 1;
    localparam int          DIV_W     = $clog2(DIV_LIMIT);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REFDIV,
        ST_FRQDIV
    } psel_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PER_W-1:0] period;
        logic             err;
        logic             zero;
    } psel_result_t;

    function automatic psel_result_t make_result(
        input logic [DIV_W-1:0] d,
        input logic [PER_W-1:0] p,
        input logic             e,
        input logic             z
    );
        psel_result_t r;
        r.div    = d;
        r.period = p;
        r.err    = e;
        r.zero   = z;
        return r;
    endfunction

endpackage

// File: rtl/psel_seqdiv.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
module psel_seqdiv #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         fin_o,
    output logic [W-1:0] quo_o
);
    localparam int CW = $clog2(W + 1);

    logic          active_q;
    logic          fin_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [W:0]    trial;
    logic          take;

    assign trial = {rem_q, quo_q[W-1]};
    assign take  = (trial >= {1'b0, den_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            fin_q    <= 1'b0;
            cnt_q    <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
            den_q    <= '0;
        end else begin
            fin_q <= 1'b0;
            if (go_i && !active_q) begin
                active_q <= 1'b1;
                cnt_q    <= CW'(W);
                rem_q    <= '0;
                quo_q    <= num_i;
                den_q    <= den_i;
            end else if (active_q) begin
                rem_q <= take ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
                quo_q <= {quo_q[W-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    active_q <= 1'b0;
                    fin_q    <= 1'b1;
                end
            end
        end
    end

    assign fin_o = fin_q;
    assign quo_o = quo_q;

endmodule

// File: rtl/psel_fit.sv
// Decides whether floor(quo / freq) stays below 2**PW without dividing.
module psel_fit #(
    parameter int QW = 25,
    parameter int FW = 25,
    parameter int PW = 16
) (
    input  logic [QW-1:0] quo_i,
    input  logic [FW-1:0] freq_i,
    output logic          fit_o
);
    localparam int CW = (QW > FW + PW) ? QW : FW + PW;

    logic [CW-1:0] q_ext;
    logic [CW-1:0] bound;

    assign q_ext = CW'(quo_i);
    assign bound = CW'({freq_i, {PW{1'b0}}});
    assign fit_o = (q_ext < bound);

endmodule

// File: rtl/psel_ctrl.sv
// Sequences the candidate search and the final period division.
module psel_ctrl
    import psel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [FREQ_W-1:0]  freq_i,
    input  logic               dv_fin_i,
    input  logic [DIVN_W-1:0]  dv_quo_i,
    input  logic               fit_i,
    output logic               dv_go_o,
    output logic [DIVN_W-1:0]  dv_num_o,
    output logic [DIVN_W-1:0]  dv_den_o,
    output logic [FREQ_W-1:0]  freq_lat_o,
    output psel_result_t       res_o,
    output logic               done_o
);
    psel_state_e        state_q;
    logic [DIV_W-1:0]   cand_q;
    logic [FREQ_W-1:0]  freq_q;
    psel_result_t       res_q;
    logic               done_q;
    logic               last_cand;
    logic [PER_W-1:0]   per_sat;

    assign last_cand = (cand_q == DIV_W'(DIV_MAX));
    assign per_sat   = (|dv_quo_i[DIVN_W-1:PER_W]) ? '1 : dv_quo_i[PER_W-1:0];

    // Divider launch requests
    always_comb begin
        dv_go_o  = 1'b0;
        dv_num_o = DIVN_W'(REF_HZ);
        dv_den_o = DIVN_W'(1);
        case (state_q)
            ST_IDLE: begin
                if (start_i && (freq_i != '0)) begin
                    dv_go_o = 1'b1;
                end
            end
            ST_REFDIV: begin
                if (dv_fin_i) begin
                    if (fit_i) begin
                        dv_go_o  = 1'b1;
                        dv_num_o = dv_quo_i;
                        dv_den_o = DIVN_W'(freq_q);
                    end else if (!last_cand) begin
                        dv_go_o  = 1'b1;
                        dv_den_o = DIVN_W'(cand_q) + DIVN_W'(1);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cand_q  <= '0;
            freq_q  <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (freq_i == '0) begin
                            res_q  <= make_result('0, '0, 1'b0, 1'b1);
                            done_q <= 1'b1;
                        end else begin
                            freq_q  <= freq_i;
                            cand_q  <= DIV_W'(1);
                            state_q <= ST_REFDIV;
                        end
                    end
                end
                ST_REFDIV: begin
                    if (dv_fin_i) begin
                        if (fit_i) begin
                            state_q <= ST_FRQDIV;
                        end else if (last_cand) begin
                            res_q   <= make_result(cand_q, '0, 1'b1, 1'b0);
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            cand_q <= cand_q + 1'b1;
                        end
                    end
                end
                ST_FRQDIV: begin
                    if (dv_fin_i) begin
                        res_q   <= make_result(cand_q, per_sat, 1'b0, 1'b0);
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign freq_lat_o = freq_q;
    assign res_o      = res_q;
    assign done_o     = done_q;

endmodule

// File: rtl/pwm_prescale_sel.sv
module pwm_prescale_sel
    import psel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [PER_W-1:0]  period_o,
    output logic              done_o,
    output logic              zero_o,
    output logic              err_o
);
    logic              dv_go;
    logic [DIVN_W-1:0] dv_num;
    logic [DIVN_W-1:0] dv_den;
    logic              dv_fin;
    logic [DIVN_W-1:0] dv_quo;
    logic              fit;
    logic [FREQ_W-1:0] freq_lat;
    psel_result_t      res;

    psel_seqdiv #(.W(DIVN_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .go_i   (dv_go),
        .num_i  (dv_num),
        .den_i  (dv_den),
        .fin_o  (dv_fin),
        .quo_o  (dv_quo)
    );

    psel_fit #(.QW(DIVN_W), .FW(FREQ_W), .PW(PER_W)) u_fit (
        .quo_i  (dv_quo),
        .freq_i (freq_lat),
        .fit_o  (fit)
    );

    psel_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .freq_i     (freq_i),
        .dv_fin_i   (dv_fin),
        .dv_quo_i   (dv_quo),
        .fit_i      (fit),
        .dv_go_o    (dv_go),
        .dv_num_o   (dv_num),
        .dv_den_o   (dv_den),
        .freq_lat_o (freq_lat),
        .res_o      (res),
        .done_o     (done_o)
    );

    assign div_o    = res.div;
    assign period_o = res.period;
    assign zero_o   = res.zero;
    assign err_o    = res.err;

endmodule

// File: rtl/psel_checker.sv
module psel_checker
    import psel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [FREQ_W-1:0] freq_i,
    input logic [DIV_W-1:0]  div_o,
    input logic [PER_W-1:0]  period_o,
    input logic              done_o,
    input logic              zero_o,
    input logic              err_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (done_o && !(start_i && freq_i == '0)) |=> !done_o) else $error("done held");      // R6
    AST_HOLD_DIV: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(div_o)) else $error("div moved");                               // R6
    AST_HOLD_PERIOD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(period_o)) else $error("period moved");                         // R6
    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(err_o) && $stable(zero_o))) else $error("flags moved");        // R6
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done_o && zero_o) |-> (div_o == '0 && period_o == '0 && !err_o)) else $error("zero"); // R2
    AST_ERR_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (div_o == DIV_W'(DIV_MAX) && period_o == '0)) else $error("err"); // R5
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
        (done_o && !zero_o) |-> (div_o != '0 && div_o <= DIV_W'(DIV_MAX))) else $error("range"); // R3
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(err_o && zero_o)) else $error("both flags");                                      // R5
endmodule

bind pwm_prescale_sel psel_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .freq_i   (freq_i),
    .div_o    (div_o),
    .period_o (period_o),
    .done_o   (done_o),
    .zero_o   (zero_o),
    .err_o    (err_o)
);

// File: tb/pwm_prescale_sel_test.sv
module pwm_prescale_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_MAX   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [24:0] freq_i = '0;
    logic [8:0]  div_o;
    logic [15:0] period_o;
    logic        done_o, zero_o, err_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_prescale_sel uut (
        .clk(clk), .rst(rst), .start_i(start_i), .freq_i(freq_i),
        .div_o(div_o), .period_o(period_o), .done_o(done_o),
        .zero_o(zero_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Independent model of the search
    function automatic void model(input longint f, output longint d, output longint p,
                                  output bit e, output bit z);
        d = 0; p = 0; e = 0; z = 0;
        if (f == 0) begin
            z = 1;
            return;
        end
        for (longint dd = 1; dd < 367; dd++) begin
            longint q = 24000000 / dd;
            if (q / f < 65536) begin
                d = dd;
                p = q / f;
                return;
            end
        end
        e = 1;
        d = 366;
    endfunction

    // Issue a request and wait for completion; cycles counts edges after acceptance
    task automatic request(input longint f, output int cycles);
        @(negedge clk);
        freq_i  = f[24:0];
        start_i = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        cycles = 0;
        while (!done_o && cycles < WAIT_MAX) begin
            @(posedge clk);
            #1;
            cycles++;
        end
    endtask

    task automatic run_and_compare(input longint f, input string req);
        int cyc;
        longint d, p;
        bit e, z;
        model(f, d, p, e, z);
        request(f, cyc);
        check(cyc < WAIT_MAX, req, "completion seen", cyc, WAIT_MAX);
        check(div_o == d, req, $sformatf("div for f=%0d", f), div_o, d);
        check(period_o == p, req, $sformatf("period for f=%0d", f), period_o, p);
        check(err_o == e, req, $sformatf("err for f=%0d", f), err_o, e);
        check(zero_o == z, req, $sformatf("zero for f=%0d", f), zero_o, z);
    endtask

    task automatic t_reset;
        check(done_o == 0 && zero_o == 0 && err_o == 0, "R1", "flags in reset", {done_o, zero_o, err_o}, 0);
        check(div_o == 0 && period_o == 0, "R1", "results in reset", period_o, 0);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(done_o == 0 && div_o == 0 && period_o == 0, "R1", "idle after reset", div_o, 0);
    endtask

    task automatic t_zero;
        int cyc;
        request(0, cyc);
        check(cyc == 0, "R2", "zero-request latency", cyc, 0);
        check(zero_o == 1 && err_o == 0, "R2", "zero flag", zero_o, 1);
        check(div_o == 0 && period_o == 0, "R2", "zero results", div_o, 0);
    endtask

    task automatic t_sweep;
        run_and_compare(12000000, "R3");
        run_and_compare(1000000, "R4");
        run_and_compare(50000, "R4");
        run_and_compare(1000, "R4");
        run_and_compare(100, "R3");
        run_and_compare(10, "R3");
        run_and_compare(3, "R3");
        run_and_compare(2, "R3");
        check(div_o == 184 && period_o == 65217, "R3", "2 Hz divider", div_o, 184);
    endtask

    task automatic t_boundary;
        run_and_compare(367, "R4");
        check(div_o == 1 && period_o == 65395, "R4", "367 Hz period", period_o, 65395);
        run_and_compare(366, "R4");
        check(div_o == 2 && period_o == 32786, "R4", "366 Hz period", period_o, 32786);
        run_and_compare(30000000, "R8");
        check(div_o == 1 && period_o == 0, "R8", "above reference", period_o, 0);
    endtask

    task automatic t_error;
        run_and_compare(1, "R5");
        check(err_o == 1 && div_o == 366 && period_o == 0, "R5", "1 Hz error result", div_o, 366);
        run_and_compare(5000, "R5");
        check(err_o == 0, "R5", "error cleared by next request", err_o, 0);
    endtask

    task automatic t_latency;
        int cyc;
        request(12000000, cyc);
        check(cyc == 52, "R9", "latency for d=1", cyc, 52);
        request(366, cyc);
        check(cyc == 78, "R9", "latency for d=2", cyc, 78);
    endtask

    task automatic t_pulse_hold;
        int cyc;
        logic [8:0]  d0;
        logic [15:0] p0;
        request(4000, cyc);
        d0 = div_o; p0 = period_o;
        @(posedge clk); #1;
        check(done_o == 0, "R6", "done width", done_o, 0);
        repeat (40) @(posedge clk);
        #1;
        check(div_o == d0 && period_o == p0, "R6", "results held", period_o, p0);
        check(done_o == 0, "R6", "no spurious done", done_o, 0);
    endtask

    task automatic t_ignore;
        int dones = 0;
        int cyc = 0;
        @(negedge clk);
        freq_i = 25'd2; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (100) @(negedge clk);
        freq_i = 25'd12000000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < WAIT_MAX) begin
            @(negedge clk);
            cyc++;
        end
        check(done_o == 1, "R7", "search completed", done_o, 1);
        check(div_o == 184 && period_o == 65217, "R7", "result of latched frequency", div_o, 184);
        repeat (80) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        check(dones == 0, "R7", "no second completion", dones, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        t_zero();
        t_sweep();
        t_boundary();
        t_error();
        t_latency();
        t_pulse_hold();
        t_ignore();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule